// File: doc/BRIEF.md
# DDR SDRAM bank timing controller

This block sits on the controller side of a four-bank double-data-rate SDRAM and turns a stream of read and write requests into the command sequence the memory expects. Each request names a bank, a row, a column, a direction and an optional auto-precharge. The block tracks which row is open in every bank. It opens, closes and reopens rows as needed, and it drives the chip-select, row-strobe, column-strobe, write-enable, bank and address pins one command per clock.

Every command waits until the clock-count gaps that guard it have run out. Each bank keeps its own counters for activate-to-activate, activate-to-precharge, activate-to-column, precharge-to-activate and write recovery. One shared set of counters guards the data bus, so a read never cuts into a write burst or its recovery time. A refresh timer derived from the clock frequency raises a refresh request at a fixed interval. That request outranks new traffic: the block closes all open banks and then issues an auto refresh. After reset the block waits, precharges all banks and programs the mode register from its parameters.

A requester holds its request steady until `req_ready` is high in a cycle. At that clock edge the column command for the request goes onto the pins.

Top module: `sdr_cmd_sched`

## Requirements
- R1: Commands on (cs_n, ras_n, cas_n, we_n) use ACTIVE=0011, READ=0101, WRITE=0100, PRECHARGE=0010, REFRESH=0001, MODE SET=0000 and NOP=0111. No other code ever appears, and the pins show NOP while reset is applied.
- R2: After reset the first command is a PRECHARGE with address bit 10 set (all banks). The second is a MODE SET with bank 0 and address = CAS latency in bits 6:4, burst type in bit 3 (1 = interleaved) and log2(burst length) in bits 2:0. With the defaults this is 0x032. The MODE SET comes at least T_RP clocks after the precharge, and no other command comes less than T_MRD clocks after the MODE SET.
- R3: A request to a closed bank produces an ACTIVE carrying that bank and the row on the address pins. The READ or WRITE that follows carries the bank, the column on address bits 8:0 and the auto-precharge flag on address bit 10. Column commands go only to an open bank holding the requested row.
- R4: A request to a bank whose open row differs from the requested row produces a single-bank PRECHARGE (address bit 10 clear) and then an ACTIVE.
- R5: On one bank, ACTIVE to ACTIVE is at least T_RC=16 clocks, PRECHARGE to ACTIVE is at least T_RP=3 clocks, and ACTIVE to READ or WRITE is at least T_RCD=3 clocks.
- R6: ACTIVE to PRECHARGE on one bank is at least T_RAS=11 clocks.
- R7: WRITE to PRECHARGE on one bank is at least BL/2+T_WR clocks. A WRITE with auto-precharge to the next ACTIVE on that bank is at least BL/2+T_DAL clocks, and a READ with auto-precharge to the next ACTIVE is at least BL/2+T_RP clocks.
- R8: A READ comes at least BL/2+T_WR clocks after any WRITE. A WRITE comes at least CAS latency+BL/2 clocks after any READ. Any two column commands are at least BL/2 clocks apart.
- R9: A REFRESH is issued only when every bank is closed and has finished its precharge time. No ACTIVE follows a REFRESH within T_RFC clocks.
- R10: The k-th REFRESH comes no earlier than k·REFI and no later than k·REFI+64 clocks after the MODE SET, where REFI = 32 ms·f/4096 (2734 clocks at 350 MHz). A pending refresh holds off new request commands.
- R11: A request that hits the open row goes straight to its column command with no ACTIVE. Each request is accepted in exactly one cycle, and requests are served in order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Command clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | A request is presented |
| req_write | input | 1 | 1 = write, 0 = read |
| req_autopre | input | 1 | Close the bank after the column command |
| req_bank | input | 2 | Bank of the request |
| req_row | input | 12 | Row of the request |
| req_col | input | 9 | Column of the request |
| req_ready | output | 1 | Request accepted at this clock edge |
| sdr_cs_n | output | 1 | Chip select, active low |
| sdr_ras_n | output | 1 | Row strobe, active low |
| sdr_cas_n | output | 1 | Column strobe, active low |
| sdr_we_n | output | 1 | Write enable, active low |
| sdr_ba | output | 2 | Bank address |
| sdr_addr | output | 12 | Row, column or mode word |

## Verification
The delicate overlap is the refresh timer expiring in the same cycle that a request becomes ready to issue, or while a request is halfway through (bank activated but column command not yet sent). The bench drives long runs of pseudo-random requests over several refresh intervals so that such collisions happen at varied points in the sequence. Every refresh is judged against its timing window and the all-banks-closed rule, and the interrupted request is judged by whether its later ACTIVE and column command still respect every gap and still carry the right row and column.

// File: rtl/sdr_sched_pkg.sv
package sdr_sched_pkg;

  // command code on {cs_n, ras_n, cas_n, we_n}
  typedef enum logic [3:0] {
    CMD_MRS = 4'b0000,
    CMD_REF = 4'b0001,
    CMD_PRE = 4'b0010,
    CMD_ACT = 4'b0011,
    CMD_WR  = 4'b0100,
    CMD_RD  = 4'b0101,
    CMD_NOP = 4'b0111
  } sdr_cmd_e;

  typedef enum logic [1:0] {
    ST_WAIT,
    ST_PALL,
    ST_MRD,
    ST_RUN
  } sdr_init_e;

endpackage

// File: rtl/sdr_bank_slot.sv
module sdr_bank_slot #(
  parameter int ROW_W     = 12,
  parameter int BURST_LEN = 4,
  parameter int T_RC      = 16,
  parameter int T_RAS     = 11,
  parameter int T_RCD     = 3,
  parameter int T_RP      = 3,
  parameter int T_WR      = 4,
  parameter int T_DAL     = 9,
  parameter int T_RFC     = 14
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             act_i,
  input  logic             pre_i,
  input  logic             rd_i,
  input  logic             wr_i,
  input  logic             ref_i,
  input  logic             ap_i,
  input  logic [ROW_W-1:0] row_i,
  output logic             open_o,
  output logic [ROW_W-1:0] row_o,
  output logic             act_ok_o,
  output logic             pre_ok_o,
  output logic             rw_ok_o
);

  localparam int HALF = BURST_LEN / 2;
  localparam int MAXV = T_RC + T_RFC + T_RAS + T_DAL + BURST_LEN + T_WR;
  localparam int CW   = $clog2(MAXV + 1);

  localparam logic [CW-1:0] L_RC   = CW'(T_RC - 1);
  localparam logic [CW-1:0] L_RAS  = CW'(T_RAS - 1);
  localparam logic [CW-1:0] L_RCD  = CW'(T_RCD - 1);
  localparam logic [CW-1:0] L_RP   = CW'(T_RP - 1);
  localparam logic [CW-1:0] L_WREC = CW'(HALF + T_WR - 1);
  localparam logic [CW-1:0] L_WAP  = CW'(HALF + T_DAL - 1);
  localparam logic [CW-1:0] L_RAP  = CW'(HALF + T_RP - 1);
  localparam logic [CW-1:0] L_RFC  = CW'(T_RFC - 1);

  function automatic logic [CW-1:0] mx(input logic [CW-1:0] a, input logic [CW-1:0] b);
    return (a > b) ? a : b;
  endfunction

  logic             open_q, open_d;
  logic [ROW_W-1:0] row_q, row_d;
  logic [CW-1:0]    act_q, act_d, act_dec;
  logic [CW-1:0]    pre_q, pre_d, pre_dec;
  logic [CW-1:0]    rw_q, rw_d, rw_dec;
  logic             upd;

  always_comb begin
    act_dec = (act_q != '0) ? act_q - 1'b1 : '0;
    pre_dec = (pre_q != '0) ? pre_q - 1'b1 : '0;
    rw_dec  = (rw_q  != '0) ? rw_q  - 1'b1 : '0;
    open_d  = open_q;
    row_d   = row_q;
    act_d   = act_dec;
    pre_d   = pre_dec;
    rw_d    = rw_dec;
    if (act_i) begin
      open_d = 1'b1;
      row_d  = row_i;
      act_d  = mx(act_dec, L_RC);
      pre_d  = mx(pre_dec, L_RAS);
      rw_d   = mx(rw_dec, L_RCD);
    end
    if (pre_i) begin
      open_d = 1'b0;
      act_d  = mx(act_dec, L_RP);
    end
    if (wr_i) begin
      pre_d = mx(pre_dec, L_WREC);
      if (ap_i) begin
        open_d = 1'b0;
        act_d  = mx(act_dec, L_WAP);
      end
    end
    if (rd_i && ap_i) begin
      open_d = 1'b0;
      act_d  = mx(act_dec, L_RAP);
    end
    if (ref_i) begin
      act_d = mx(act_dec, L_RFC);
    end
    upd = act_i | pre_i | rd_i | wr_i | ref_i |
          (act_q != '0) | (pre_q != '0) | (rw_q != '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      open_q <= 1'b0;
      row_q  <= '0;
      act_q  <= '0;
      pre_q  <= '0;
      rw_q   <= '0;
    end else if (upd) begin
      open_q <= open_d;
      row_q  <= row_d;
      act_q  <= act_d;
      pre_q  <= pre_d;
      rw_q   <= rw_d;
    end
  end

  assign open_o   = open_q;
  assign row_o    = row_q;
  assign act_ok_o = (act_q == '0);
  assign pre_ok_o = (pre_q == '0);
  assign rw_ok_o  = (rw_q == '0);

  AST_ACT_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    act_i |-> (act_q == '0 && !open_q)); // R5
  AST_PRE_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    (pre_i && open_q) |-> (pre_q == '0)); // R6
  AST_COL_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_i || wr_i) |-> (open_q && rw_q == '0)); // R3
  AST_REF_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    ref_i |-> (!open_q && act_q == '0)); // R9

endmodule

// File: rtl/sdr_bus_slot.sv
module sdr_bus_slot #(
  parameter int BURST_LEN = 4,
  parameter int CAS_LAT   = 3,
  parameter int T_WR      = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rd_i,
  input  logic wr_i,
  output logic rd_ok_o,
  output logic wr_ok_o
);

  localparam int HALF = BURST_LEN / 2;
  localparam int CW   = $clog2(HALF + T_WR + CAS_LAT + 1);

  localparam logic [CW-1:0] L_GAP = CW'(HALF - 1);
  localparam logic [CW-1:0] L_W2R = CW'(HALF + T_WR - 1);
  localparam logic [CW-1:0] L_R2W = CW'(CAS_LAT + HALF - 1);

  logic [CW-1:0] gap_q, gap_d;
  logic [CW-1:0] w2r_q, w2r_d;
  logic [CW-1:0] r2w_q, r2w_d;

  always_comb begin
    gap_d = (gap_q != '0) ? gap_q - 1'b1 : '0;
    w2r_d = (w2r_q != '0) ? w2r_q - 1'b1 : '0;
    r2w_d = (r2w_q != '0) ? r2w_q - 1'b1 : '0;
    if (rd_i || wr_i) gap_d = L_GAP;
    if (wr_i)         w2r_d = L_W2R;
    if (rd_i)         r2w_d = L_R2W;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap_q <= '0;
      w2r_q <= '0;
      r2w_q <= '0;
    end else begin
      gap_q <= gap_d;
      w2r_q <= w2r_d;
      r2w_q <= r2w_d;
    end
  end

  assign rd_ok_o = (gap_q == '0) && (w2r_q == '0);
  assign wr_ok_o = (gap_q == '0) && (r2w_q == '0);

  AST_NO_RD_IN_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    rd_i |-> (w2r_q == '0 && gap_q == '0)); // R8
  AST_NO_WR_IN_READ: assert property (@(posedge clk) disable iff (!rst_n)
    wr_i |-> (r2w_q == '0 && gap_q == '0)); // R8

  always_comb begin
    if (rst_n) begin
      AST_ONE_COLUMN: assert (!(rd_i && wr_i)); // R8
    end
  end

endmodule

// File: rtl/sdr_refresh_tick.sv
module sdr_refresh_tick #(
  parameter int REFI = 2734
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en_i,
  input  logic ack_i,
  output logic pend_o
);

  localparam int CW = $clog2(REFI + 1);
  localparam logic [CW-1:0] L_REFI = CW'(REFI - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          pend_q, pend_d;
  logic          expire;

  always_comb begin
    expire = en_i && (cnt_q == '0);
    cnt_d  = cnt_q;
    pend_d = pend_q;
    if (en_i) cnt_d = expire ? L_REFI : cnt_q - 1'b1;
    if (ack_i) pend_d = 1'b0;
    if (expire) pend_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= L_REFI;
      pend_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      pend_q <= pend_d;
    end
  end

  assign pend_o = pend_q;

  AST_PEND_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && !ack_i) |=> pend_q); // R10
  AST_ACK_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    ack_i |-> pend_q); // R10

endmodule

// File: rtl/sdr_cmd_sched.sv
module sdr_cmd_sched
  import sdr_sched_pkg::*;
#(
  parameter int NUM_BANKS    = 4,
  parameter int ROW_W        = 12,
  parameter int COL_W        = 9,
  parameter int AP_BIT       = 10,
  parameter int CLK_MHZ      = 350,
  parameter int REFRESH_MS   = 32,
  parameter int REFRESH_ROWS = 4096,
  parameter int CAS_LAT      = 3,
  parameter int BURST_LEN    = 4,
  parameter int INTERLEAVE   = 0,
  parameter int T_RC         = 16,
  parameter int T_RAS        = 11,
  parameter int T_RCD        = 3,
  parameter int T_RP         = 3,
  parameter int T_WR         = 4,
  parameter int T_DAL        = 9,
  parameter int T_RFC        = 14,
  parameter int T_MRD        = 2,
  parameter int INIT_WAIT    = 200
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         req_valid,
  input  logic                         req_write,
  input  logic                         req_autopre,
  input  logic [$clog2(NUM_BANKS)-1:0] req_bank,
  input  logic [ROW_W-1:0]             req_row,
  input  logic [COL_W-1:0]             req_col,
  output logic                         req_ready,
  output logic                         sdr_cs_n,
  output logic                         sdr_ras_n,
  output logic                         sdr_cas_n,
  output logic                         sdr_we_n,
  output logic [$clog2(NUM_BANKS)-1:0] sdr_ba,
  output logic [ROW_W-1:0]             sdr_addr
);

  localparam int BA_W   = $clog2(NUM_BANKS);
  localparam int ADDR_W = ROW_W;
  localparam int REFI   = (REFRESH_MS * 1000 * CLK_MHZ) / REFRESH_ROWS;
  localparam int GMAX   = (INIT_WAIT > T_MRD) ? INIT_WAIT : T_MRD;
  localparam int GW     = $clog2(GMAX + 1);
  localparam int MODE_I = (CAS_LAT << 4) | (INTERLEAVE << 3) | $clog2(BURST_LEN);
  localparam logic [ADDR_W-1:0] MODE_WORD = ADDR_W'(MODE_I);

  // reset: asserted at once, released on the clock
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  // per-bank state
  logic [NUM_BANKS-1:0] act_v, pre_v, rd_v, wr_v;
  logic [NUM_BANKS-1:0] bank_open, act_ok, pre_ok, rw_ok;
  logic [ROW_W-1:0]     bank_row [NUM_BANKS];
  logic                 ap_d, ref_go;

  for (genvar gi = 0; gi < NUM_BANKS; gi++) begin : g_bank
    sdr_bank_slot #(
      .ROW_W(ROW_W), .BURST_LEN(BURST_LEN), .T_RC(T_RC), .T_RAS(T_RAS),
      .T_RCD(T_RCD), .T_RP(T_RP), .T_WR(T_WR), .T_DAL(T_DAL), .T_RFC(T_RFC)
    ) u_bank (
      .clk      (clk),
      .rst_n    (rst_int_n),
      .act_i    (act_v[gi]),
      .pre_i    (pre_v[gi]),
      .rd_i     (rd_v[gi]),
      .wr_i     (wr_v[gi]),
      .ref_i    (ref_go),
      .ap_i     (ap_d),
      .row_i    (req_row),
      .open_o   (bank_open[gi]),
      .row_o    (bank_row[gi]),
      .act_ok_o (act_ok[gi]),
      .pre_ok_o (pre_ok[gi]),
      .rw_ok_o  (rw_ok[gi])
    );
  end

  // shared data bus spacing
  logic rd_any, wr_any, rd_ok, wr_ok;
  assign rd_any = |rd_v;
  assign wr_any = |wr_v;

  sdr_bus_slot #(.BURST_LEN(BURST_LEN), .CAS_LAT(CAS_LAT), .T_WR(T_WR)) u_bus (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .rd_i    (rd_any),
    .wr_i    (wr_any),
    .rd_ok_o (rd_ok),
    .wr_ok_o (wr_ok)
  );

  // refresh interval
  sdr_init_e st_q, st_d;
  logic      ref_pend;

  sdr_refresh_tick #(.REFI(REFI)) u_refresh (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .en_i   (st_q == ST_RUN),
    .ack_i  (ref_go),
    .pend_o (ref_pend)
  );

  // sequencer
  logic [GW-1:0]     gcnt_q, gcnt_d;
  sdr_cmd_e          cmd_q, cmd_d;
  logic [BA_W-1:0]   ba_q, ba_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic              any_open, open_busy, row_hit, col_ok;

  always_comb begin
    any_open  = |bank_open;
    open_busy = |(bank_open & ~pre_ok);
    row_hit   = bank_open[req_bank] && (bank_row[req_bank] == req_row);
    col_ok    = rw_ok[req_bank] && (req_write ? wr_ok : rd_ok) &&
                (!req_autopre || pre_ok[req_bank]);
  end

  always_comb begin
    st_d      = st_q;
    gcnt_d    = (gcnt_q != '0) ? gcnt_q - 1'b1 : '0;
    cmd_d     = CMD_NOP;
    ba_d      = '0;
    addr_d    = '0;
    act_v     = '0;
    pre_v     = '0;
    rd_v      = '0;
    wr_v      = '0;
    ap_d      = 1'b0;
    ref_go    = 1'b0;
    req_ready = 1'b0;
    case (st_q)
      ST_WAIT: begin
        if (gcnt_q == '0) begin
          cmd_d          = CMD_PRE;
          addr_d[AP_BIT] = 1'b1;
          pre_v          = '1;
          st_d           = ST_PALL;
        end
      end
      ST_PALL: begin
        if (&act_ok) begin
          cmd_d  = CMD_MRS;
          addr_d = MODE_WORD;
          gcnt_d = GW'(T_MRD - 1);
          st_d   = ST_MRD;
        end
      end
      ST_MRD: begin
        if (gcnt_q == '0) st_d = ST_RUN;
      end
      default: begin
        if (ref_pend) begin
          if (any_open) begin
            if (!open_busy) begin
              cmd_d          = CMD_PRE;
              addr_d[AP_BIT] = 1'b1;
              pre_v          = '1;
            end
          end else if (&act_ok) begin
            cmd_d  = CMD_REF;
            ref_go = 1'b1;
          end
        end else if (req_valid) begin
          if (row_hit) begin
            if (col_ok) begin
              cmd_d          = req_write ? CMD_WR : CMD_RD;
              ba_d           = req_bank;
              addr_d         = ADDR_W'(req_col);
              addr_d[AP_BIT] = req_autopre;
              ap_d           = req_autopre;
              req_ready      = 1'b1;
              if (req_write) wr_v[req_bank] = 1'b1;
              else           rd_v[req_bank] = 1'b1;
            end
          end else if (bank_open[req_bank]) begin
            if (pre_ok[req_bank]) begin
              cmd_d          = CMD_PRE;
              ba_d           = req_bank;
              pre_v[req_bank] = 1'b1;
            end
          end else if (act_ok[req_bank]) begin
            cmd_d           = CMD_ACT;
            ba_d            = req_bank;
            addr_d          = req_row;
            act_v[req_bank] = 1'b1;
          end
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      st_q   <= ST_WAIT;
      gcnt_q <= GW'(INIT_WAIT - 1);
      cmd_q  <= CMD_NOP;
      ba_q   <= '0;
      addr_q <= '0;
    end else begin
      st_q   <= st_d;
      gcnt_q <= gcnt_d;
      cmd_q  <= cmd_d;
      ba_q   <= ba_d;
      addr_q <= addr_d;
    end
  end

  assign {sdr_cs_n, sdr_ras_n, sdr_cas_n, sdr_we_n} = cmd_q;
  assign sdr_ba   = ba_q;
  assign sdr_addr = addr_q;

  AST_LEGAL_CODE: assert property (@(posedge clk) disable iff (!rst_int_n)
    cmd_q inside {CMD_MRS, CMD_REF, CMD_PRE, CMD_ACT, CMD_WR, CMD_RD, CMD_NOP}); // R1
  AST_ONE_ACT: assert property (@(posedge clk) disable iff (!rst_int_n)
    $onehot0(act_v)); // R3
  AST_REF_FIRST: assert property (@(posedge clk) disable iff (!rst_int_n)
    ref_pend |-> ($countones(act_v | rd_v | wr_v) == 0 && !req_ready)); // R10
  AST_ACCEPT_COLUMN: assert property (@(posedge clk) disable iff (!rst_int_n)
    req_ready |=> (cmd_q == CMD_RD || cmd_q == CMD_WR)); // R11
  AST_RUN_AFTER_MODE: assert property (@(posedge clk) disable iff (!rst_int_n)
    (st_q != ST_RUN) |-> (act_v == '0 && !ref_go && !req_ready)); // R2

endmodule

// File: tb/sdr_cmd_sched_tb.sv
module sdr_cmd_sched_tb;

  localparam int CLK_PERIOD = 10;
  localparam int TRC = 16, TRAS = 11, TRCD = 3, TRP = 3, TWR = 4, TDAL = 9;
  localparam int TRFC = 14, TMRD = 2, CL = 3, BL = 4, HALF = BL / 2;
  localparam int REFI = 2734, SLACK = 64;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_write, req_autopre;
  logic [1:0]  req_bank;
  logic [11:0] req_row;
  logic [8:0]  req_col;
  logic        req_ready;
  logic        cs_n, ras_n, cas_n, we_n;
  logic [1:0]  ba;
  logic [11:0] addr;

  sdr_cmd_sched u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_autopre(req_autopre), .req_bank(req_bank), .req_row(req_row),
    .req_col(req_col), .req_ready(req_ready), .sdr_cs_n(cs_n),
    .sdr_ras_n(ras_n), .sdr_cas_n(cas_n), .sdr_we_n(we_n),
    .sdr_ba(ba), .sdr_addr(addr)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  int n_tests = 0, n_fail = 0;
  int cyc = 0, served = 0, act_count = 0, ref_count = 0, t_mrs = 0, t_pre0 = 0;
  bit mrs_seen = 0, pre0_seen = 0, done = 0;
  bit open_m[4];
  int row_m[4], last_act[4], last_pre[4], last_wr[4], wr_ap[4], rd_ap[4];
  int last_rd_any = -1000, last_wr_any = -1000, last_col = -1000, last_ref = -1000;
  bit exp_valid = 0, exp_write = 0, exp_ap = 0;
  int exp_bank = 0, exp_row = 0, exp_col = 0;

  task automatic chk(input bit ok, input string rq, input int act, input int exp,
                     input string what);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: got %0d expected %0d", rq, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  endtask

  task automatic pre_bank_checks(input int b);
    if (open_m[b]) begin
      chk(cyc - last_act[b] >= TRAS, "R6", cyc - last_act[b], TRAS, "ACT to PRE");
      chk(cyc - last_wr[b] >= HALF + TWR, "R7", cyc - last_wr[b], HALF + TWR, "WR to PRE");
    end
    open_m[b] = 0;
    last_pre[b] = cyc;
  endtask

  // command monitor and timing model, sampled a quarter period after each edge
  task automatic monitor_step();
    logic [3:0] c;
    int b;
    c = {cs_n, ras_n, cas_n, we_n};
    b = int'(ba);
    case (c)
      4'b0111: ;
      4'b0010: begin
        if (!pre0_seen) begin
          chk(addr[10] == 1'b1 && !mrs_seen, "R2", int'(addr[10]), 1, "first command is PRE all");
          pre0_seen = 1;
          t_pre0 = cyc;
        end
        if (addr[10]) begin
          for (int i = 0; i < 4; i++) pre_bank_checks(i);
        end else begin
          chk(open_m[b], "R4", int'(open_m[b]), 1, "single PRE on open bank");
          chk(exp_valid && b == exp_bank && row_m[b] != exp_row, "R4", b, exp_bank,
              "single PRE only on row miss");
          pre_bank_checks(b);
        end
      end
      4'b0000: begin
        chk(pre0_seen && !mrs_seen, "R2", int'(mrs_seen), 0, "MODE SET order");
        chk(addr == 12'h032 && ba == 2'd0, "R2", int'(addr), 'h32, "mode word");
        chk(cyc - t_pre0 >= TRP, "R2", cyc - t_pre0, TRP, "PRE all to MODE SET");
        mrs_seen = 1;
        t_mrs = cyc;
      end
      4'b0011: begin
        chk(mrs_seen && cyc - t_mrs >= TMRD, "R2", cyc - t_mrs, TMRD, "MODE SET to ACT");
        chk(!open_m[b], "R3", int'(open_m[b]), 0, "ACT on closed bank");
        chk(exp_valid && b == exp_bank, "R3", b, exp_bank, "ACT bank");
        chk(int'(addr) == exp_row, "R3", int'(addr), exp_row, "ACT row");
        chk(cyc - last_act[b] >= TRC, "R5", cyc - last_act[b], TRC, "ACT to ACT");
        chk(cyc - last_pre[b] >= TRP, "R5", cyc - last_pre[b], TRP, "PRE to ACT");
        chk(cyc - last_ref >= TRFC, "R9", cyc - last_ref, TRFC, "REF to ACT");
        chk(cyc - wr_ap[b] >= HALF + TDAL, "R7", cyc - wr_ap[b], HALF + TDAL, "WR-AP to ACT");
        chk(cyc - rd_ap[b] >= HALF + TRP, "R7", cyc - rd_ap[b], HALF + TRP, "RD-AP to ACT");
        open_m[b] = 1;
        row_m[b] = int'(addr);
        last_act[b] = cyc;
        act_count++;
      end
      4'b0101, 4'b0100: begin
        bit is_wr;
        is_wr = (c == 4'b0100);
        chk(mrs_seen && cyc - t_mrs >= TMRD, "R2", cyc - t_mrs, TMRD, "MODE SET to column");
        chk(open_m[b] && row_m[b] == exp_row, "R3", row_m[b], exp_row, "column on open row");
        chk(exp_valid && is_wr == exp_write && b == exp_bank, "R11", b, exp_bank,
            "column bank and direction in order");
        chk(int'(addr[8:0]) == exp_col, "R3", int'(addr[8:0]), exp_col, "column address");
        chk(addr[10] == exp_ap, "R3", int'(addr[10]), int'(exp_ap), "auto-precharge flag");
        chk(cyc - last_act[b] >= TRCD, "R5", cyc - last_act[b], TRCD, "ACT to column");
        chk(cyc - last_col >= HALF, "R8", cyc - last_col, HALF, "column spacing");
        if (is_wr)
          chk(cyc - last_rd_any >= CL + HALF, "R8", cyc - last_rd_any, CL + HALF, "RD to WR");
        else
          chk(cyc - last_wr_any >= HALF + TWR, "R8", cyc - last_wr_any, HALF + TWR, "WR to RD");
        last_col = cyc;
        if (is_wr) begin
          last_wr_any = cyc;
          last_wr[b] = cyc;
          if (addr[10]) begin open_m[b] = 0; wr_ap[b] = cyc; end
        end else begin
          last_rd_any = cyc;
          if (addr[10]) begin open_m[b] = 0; rd_ap[b] = cyc; end
        end
        exp_valid = 0;
        served++;
      end
      4'b0001: begin
        int lo;
        lo = t_mrs + (ref_count + 1) * REFI;
        for (int i = 0; i < 4; i++) begin
          chk(!open_m[i], "R9", int'(open_m[i]), 0, "bank closed at REF");
          chk(cyc - last_pre[i] >= TRP, "R9", cyc - last_pre[i], TRP, "PRE to REF");
        end
        chk(cyc >= lo && cyc <= lo + SLACK, "R10", cyc, lo, "refresh time window");
        last_ref = cyc;
        ref_count++;
      end
      default: chk(1'b0, "R1", int'(c), 7, "illegal command code");
    endcase
  endtask

  initial begin
    for (int i = 0; i < 4; i++) begin
      open_m[i] = 0; row_m[i] = -1; last_act[i] = -1000; last_pre[i] = -1000;
      last_wr[i] = -1000; wr_ap[i] = -1000; rd_ap[i] = -1000;
    end
    forever begin
      @(posedge clk);
      #(CLK_PERIOD / 4);
      if (rst_n) begin
        cyc++;
        monitor_step();
      end
    end
  end

  task automatic issue(input bit w, input bit ap, input int b, input int row, input int col);
    int s0, rdy;
    @(negedge clk);
    req_valid = 1; req_write = w; req_autopre = ap;
    req_bank = 2'(b); req_row = 12'(row); req_col = 9'(col);
    exp_write = w; exp_ap = ap; exp_bank = b; exp_row = row; exp_col = col;
    exp_valid = 1;
    s0 = served; rdy = 0;
    forever begin
      #1;
      if (req_ready) rdy++;
      @(negedge clk);
      if (served != s0) break;
    end
    req_valid = 0;
    chk(rdy == 1, "R11", rdy, 1, "accept cycles per request");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk(1'b0, "R1", 0, 1, "watchdog expired");
    finish_run();
  end

  initial begin
    logic [31:0] seed;
    int a0;
    rst_n = 0; req_valid = 0; req_write = 0; req_autopre = 0;
    req_bank = 0; req_row = 0; req_col = 0;
    repeat (4) @(negedge clk);
    chk({cs_n, ras_n, cas_n, we_n} == 4'b0111, "R1", int'({cs_n, ras_n, cas_n, we_n}), 7,
        "NOP during reset");
    chk(req_ready == 1'b0, "R1", int'(req_ready), 0, "no accept during reset");
    rst_n = 1;
    while (!mrs_seen) @(negedge clk);
    repeat (5) @(negedge clk);

    issue(1, 0, 0, 5, 8);
    a0 = act_count;
    issue(0, 0, 0, 5, 9);                          // R11 row hit, R8 write then read
    chk(act_count == a0, "R11", act_count, a0, "no ACT on row hit");
    issue(0, 0, 0, 7, 3);                          // R4 row miss
    chk(act_count == a0 + 1, "R4", act_count, a0 + 1, "one ACT after row miss");
    issue(1, 1, 1, 100, 0);                        // R7 write with auto-precharge
    issue(1, 1, 1, 101, 4);
    issue(0, 1, 2, 9, 1);                          // R5 tRC via read auto-precharge
    issue(0, 1, 2, 10, 2);
    issue(1, 0, 3, 2, 5);
    issue(1, 0, 3, 3, 6);                          // R7 write recovery before PRE
    issue(0, 0, 3, 3, 7);                          // R8 read after write
    issue(0, 0, 1, 50, 0);
    issue(1, 0, 1, 50, 1);                         // R8 write after read

    repeat (3 * REFI + 100) @(negedge clk);
    chk(ref_count >= 3, "R9", ref_count, 3, "refreshes while idle");

    seed = 32'h1234_5678;
    for (int n = 0; n < 400; n++) begin
      seed = seed * 32'd1103515245 + 32'd12345;
      issue(seed[20], seed[21] & seed[22], int'(seed[17:16]), int'(seed[25:24]),
            int'(seed[14:6]));
    end
    repeat (20) @(negedge clk);
    chk(ref_count >= (cyc - t_mrs) / REFI - 1, "R10", ref_count, (cyc - t_mrs) / REFI - 1,
        "no refresh dropped");
    finish_run();
  end

endmodule